// File: doc/BRIEF.md
# Stable Hardware Priority Queue

A fixed-capacity queue that keeps tagged data words in order of urgency. Each entry is a payload word with a priority level. The producer offers an entry on the push side. The consumer always sees, and can take, the most urgent entry that is currently held. Among entries of equal urgency, the one that arrived first leaves first.

Ordering happens when an entry is written. Storage is a shift array that is always sorted, with the head in slot 0. Removing the head is therefore a single-cycle shift, and the head is visible straight from a register. A push and a pop can happen in the same cycle. Full, empty and occupancy outputs are provided. Pushes into a full queue and pops from an empty queue are rejected and reported with one-cycle flags.

Top module: `prio_queue`

## Requirements
- R1: An entry with a numerically higher priority always leaves before any entry held with a lower priority.
- R2: Entries with equal priority leave in the order in which they were accepted.
- R3: When the queue is not empty, `head_valid_o` is 1 and `head_prio_o`/`head_data_o` show the most urgent entry, straight from registers. An entry pushed into an empty queue appears there one clock edge after it is accepted.
- R4: A push and a pop in the same cycle, with the queue neither empty nor full, are both accepted. The entry removed is the head shown before that edge, and the count does not change.
- R5: A push while the queue is full and no pop is issued is ignored, and the contents do not change. `overflow_o` is 1 for exactly the one cycle after that edge.
- R6: A pop while the queue is empty is ignored, and `underflow_o` is 1 for exactly the one cycle after that edge.
- R7: `count_o` gives the number of entries held and changes at the same edge as each accepted push or pop. `full_o` is 1 exactly when the count equals the depth (8), and `empty_o` is 1 exactly when the count is 0.
- R8: When the queue is full, a push together with a pop in the same cycle are both accepted. The head leaves, the new entry is placed by priority, and the queue stays full without raising `overflow_o`.
- R9: After reset the queue is empty, the count is 0, `head_valid_o` is 0, and both error flags are 0.
- R10: The priority is a 3-bit unsigned value. 7 is the most urgent level and 0 the least.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Offer an entry this cycle |
| push_prio_i | input | 3 | Priority of the offered entry, 7 most urgent |
| push_data_i | input | 16 | Payload of the offered entry |
| pop_i | input | 1 | Remove the head entry this cycle |
| head_valid_o | output | 1 | Head outputs hold an entry |
| head_prio_o | output | 3 | Priority of the head entry |
| head_data_o | output | 16 | Payload of the head entry |
| count_o | output | 4 | Number of entries held |
| full_o | output | 1 | Queue holds 8 entries |
| empty_o | output | 1 | Queue holds no entries |
| overflow_o | output | 1 | A push was rejected at the previous edge |
| underflow_o | output | 1 | A pop was rejected at the previous edge |

## Verification
The properties assume that `push_i` and `pop_i` are driven to known levels in every cycle after reset. They also assume that the priority and payload are stable over the clock edge at which a push is sampled, because the count and ordering checks compare one edge against the previous one. The bench changes every input only at the falling clock edge and holds it through the next rising edge. The bench never leaves a strobe undefined. It deliberately drives pushes into a full queue and pops from an empty one, so that the rejection paths are covered without breaking those assumptions.

// File: rtl/prio_queue.sv
module prio_queue #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              head_valid_o,
  output logic [PRIO_W-1:0] head_prio_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PRIO_W-1:0] sh_prio [DEPTH];
  logic [DATA_W-1:0] sh_data [DEPTH];
  logic [PRIO_W-1:0] nx_prio [DEPTH];
  logic [DATA_W-1:0] nx_data [DEPTH];
  logic [CNT_W-1:0]  count_q, base_n, ins_pos;
  logic              ovf_q, udf_q, pop_ok, push_ok;

  assign full_o       = count_q == CNT_W'(DEPTH);
  assign empty_o      = count_q == '0;
  assign pop_ok       = pop_i && !empty_o;
  assign push_ok      = push_i && (!full_o || pop_ok);
  assign base_n       = count_q - CNT_W'(pop_ok);
  assign head_valid_o = !empty_o;
  assign head_prio_o  = prio_q[0];
  assign head_data_o  = data_q[0];
  assign count_o      = count_q;
  assign overflow_o   = ovf_q;
  assign underflow_o  = udf_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      assign sh_prio[g] = pop_ok ? prio_q[g+1] : prio_q[g];
      assign sh_data[g] = pop_ok ? data_q[g+1] : data_q[g];
    end else begin : g_last
      assign sh_prio[g] = prio_q[g];
      assign sh_data[g] = data_q[g];
    end
  end

  always_comb begin
    ins_pos = '0;
    for (int j = 0; j < DEPTH; j++)
      if (CNT_W'(j) < base_n && sh_prio[j] >= push_prio_i)
        ins_pos = ins_pos + CNT_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ins
    if (g == 0) begin : g_head
      assign nx_prio[g] = (push_ok && ins_pos == '0) ? push_prio_i : sh_prio[g];
      assign nx_data[g] = (push_ok && ins_pos == '0) ? push_data_i : sh_data[g];
    end else begin : g_rest
      assign nx_prio[g] = (!push_ok || CNT_W'(g) < ins_pos) ? sh_prio[g] :
                          (CNT_W'(g) == ins_pos) ? push_prio_i : sh_prio[g-1];
      assign nx_data[g] = (!push_ok || CNT_W'(g) < ins_pos) ? sh_data[g] :
                          (CNT_W'(g) == ins_pos) ? push_data_i : sh_data[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      ovf_q   <= push_i && !push_ok;
      udf_q   <= pop_i && empty_o;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= nx_prio[i];
        data_q[i] <= nx_data[i];
      end
    end
  end
endmodule

// File: rtl/prio_queue_chk.sv
module prio_queue_chk #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic              head_valid_o,
  input logic [PRIO_W-1:0] head_prio_o,
  input logic [DATA_W-1:0] head_data_o,
  input logic [$clog2(DEPTH+1)-1:0] count_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              overflow_o,
  input logic              underflow_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_o) <= DEPTH);  // R7
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i && !full_o |=> count_o == $past(count_o) + 1'b1);  // R7
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && !empty_o |=> count_o == $past(count_o) - 1'b1);  // R7
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !empty_o |=> count_o == $past(count_o) && !overflow_o);  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && full_o && !pop_i |=> overflow_o && full_o && $stable(head_data_o));  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && empty_o && !push_i |=> underflow_o && empty_o);  // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i && !pop_i |=> $stable(count_o) && $stable(head_data_o) && !overflow_o && !underflow_o);  // R3
  AST_HEAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && count_o > 1 |=> head_prio_o <= $past(head_prio_o));  // R1
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid_o == !empty_o);  // R3
endmodule

bind prio_queue prio_queue_chk #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .head_valid_o(head_valid_o), .head_prio_o(head_prio_o), .head_data_o(head_data_o),
  .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o));

// File: tb/prio_queue_tb.sv
module prio_queue_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0;
  logic [2:0]  push_prio_i = '0;
  logic [15:0] push_data_i = '0;
  logic        head_valid_o, full_o, empty_o, overflow_o, underflow_o;
  logic [2:0]  head_prio_o;
  logic [15:0] head_data_o;
  logic [3:0]  count_o;

  typedef struct { logic [2:0] prio; logic [15:0] data; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit exp_ovf = 1'b0, exp_udf = 1'b0;

  always #4 clk = ~clk;

  prio_queue dut_i (.*);

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic monitor();
    check(int'(count_o) == sb.size(), "R7 count", count_o, sb.size());
    check(full_o == (sb.size() == 8), "R7 full", full_o, sb.size() == 8);
    check(empty_o == (sb.size() == 0), "R7 empty", empty_o, sb.size() == 0);
    check(head_valid_o == (sb.size() != 0), "R3 valid", head_valid_o, sb.size() != 0);
    if (sb.size() != 0) begin
      check(head_prio_o == sb[0].prio, "R3 head prio", head_prio_o, sb[0].prio);
      check(head_data_o == sb[0].data, "R3 head data", head_data_o, sb[0].data);
    end
    check(overflow_o == exp_ovf, "R5 overflow", overflow_o, exp_ovf);
    check(underflow_o == exp_udf, "R6 underflow", underflow_o, exp_udf);
  endtask

  task automatic drive(bit ps, logic [2:0] pr, logic [15:0] d, bit pp);
    int k;
    bit was_full;
    item_t it;
    @(negedge clk);
    push_i = ps; push_prio_i = pr; push_data_i = d; pop_i = pp;
    was_full = sb.size() == 8;
    exp_udf = pp && sb.size() == 0;
    exp_ovf = ps && was_full && !pp;
    if (pp && sb.size() != 0) begin
      check(head_data_o == sb[0].data, ps ? "R4 popped" : "R1 R2 popped", head_data_o, sb[0].data);
      void'(sb.pop_front());
    end
    if (ps && sb.size() < 8) begin
      it.prio = pr; it.data = d;
      k = 0;
      while (k < sb.size() && sb[k].prio >= pr) k++;
      sb.insert(k, it);
    end
    @(posedge clk); #1;
    monitor();
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; monitor(); // R9 reset state
    rst_n = 1'b1;
    // R10 R1 R2: mixed levels, 7 most urgent, ties in arrival order
    drive(1, 3, 16'hA001, 0);
    drive(1, 5, 16'hB002, 0);
    drive(1, 3, 16'hA003, 0);
    drive(1, 7, 16'hD004, 0);
    drive(1, 5, 16'hB005, 0);
    drive(1, 0, 16'hF006, 0);
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);                    // R6 pop when empty
    drive(0, 0, 0, 0);
    for (int i = 0; i < 8; i++) drive(1, 3'(i % 3), 16'h1000 + 16'(i), 0);
    drive(1, 7, 16'hEEEE, 0);             // R5 push when full
    drive(0, 0, 0, 0);
    drive(1, 1, 16'h2222, 1);             // R8 push with pop when full
    drive(1, 6, 16'h3333, 1);             // R8
    drive(0, 0, 0, 1);
    drive(1, 2, 16'h4444, 1);             // R4 mid occupancy
    for (int i = 0; i < 300; i++)
      drive(($urandom % 3) != 0, 3'($urandom), 16'(i + 16'h5000), ($urandom % 2) != 0);
    while (sb.size() != 0) drive(0, 0, 0, 1);
    drive(0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule